// File: doc/BRIEF.md
# Bidirectional Shift and Storage Register with Shared Parallel Pins

This block is a register of `WIDTH` bits (eight by default) that changes only on the rising clock edge. A two-bit mode input selects one of four operations:

- hold the contents;
- shift toward the high end;
- shift toward the low end;
- load all bits from the parallel pins.

A synchronous active-low clear takes priority over every mode. The parallel pins are shared between loading and reading back. They are modelled as three signals: an input bus, an output bus and a single drive-enable. The pad ring merges these into one bidirectional bus.

The drive-enable is purely combinational. It is high only when both active-low enables are low and the mode is not "load". Selecting load therefore frees the pins so that an external source can present data to them. Two single-bit taps always show the lowest and highest register bits, even while the shared pins are undriven. Chaining instances tap to serial input builds longer registers.

Top module: `bidir_shift_reg`

## Requirements
- R1: When `rst_n` is 0 at a rising clock edge, every register bit becomes 0 on that edge, whatever `mode` holds.
- R2: With `rst_n` high and `mode` = 2'b11 (load), each register bit takes the matching bit of `par_in` at the edge.
- R3: With `mode` = 2'b01 (shift up), bit 0 takes `ser_lo` and every bit n takes the former bit n-1.
- R4: With `mode` = 2'b10 (shift down), bit WIDTH-1 takes `ser_hi` and every bit n takes the former bit n+1.
- R5: With `mode` = 2'b00 (hold), the register keeps its value.
- R6: `par_drive` is 0 whenever `en_a_n` or `en_b_n` is 1.
- R7: `par_drive` is 0 whenever `mode` = 2'b11, and it is 1 when both enables are 0 and `mode` is any other value. `par_out` shows the register contents in every cycle.
- R8: The clear, load, shift and hold operations work the same while `par_drive` is 0.
- R9: `tap_lo` equals register bit 0 and `tap_hi` equals bit WIDTH-1 at all times, independent of the enables.
- R10: Two instances sharing mode, clear and clock form a 2×WIDTH register when connected as follows:
  - the lower instance's `tap_hi` drives the upper instance's `ser_lo`;
  - the upper instance's `tap_lo` drives the lower instance's `ser_hi`.

  The chain then shifts in both directions across the seam.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous clear, active low |
| mode | input | 2 | 00 hold, 01 shift up, 10 shift down, 11 load |
| en_a_n | input | 1 | First pin-drive enable, active low |
| en_b_n | input | 1 | Second pin-drive enable, active low |
| ser_lo | input | 1 | Serial input entering bit 0 on shift up |
| ser_hi | input | 1 | Serial input entering bit WIDTH-1 on shift down |
| par_in | input | WIDTH | Value sensed on the shared pins |
| par_out | output | WIDTH | Register value offered to the shared pins |
| par_drive | output | 1 | High when the shared pins are driven |
| tap_lo | output | 1 | Always-on copy of bit 0 |
| tap_hi | output | 1 | Always-on copy of bit WIDTH-1 |

## Verification
The clear can fall in the same cycle as a load or a shift. The bench holds `rst_n` low while `mode` selects load with a non-zero `par_in`, and separately while it selects a shift with the serial inputs at 1. It then expects all-zero contents after that edge.

Load selection and driver release also coincide. With both enables low, the bench switches `mode` to 2'b11 and expects two things:
- `par_drive` falls before the edge;
- the loaded value appears after the edge.

Random cycles mix all four of these conditions against a reference model of a 16-bit chained register.

// File: rtl/shreg_pkg.sv
// Package: shared mode encoding for the bidirectional shift register.
// Assumes the two mode bits arrive as a plain vector at the top level.
package shreg_pkg;

    // Mode codes; the values are fixed because callers drive them directly.
    typedef enum logic [1:0] {
        MODE_HOLD = 2'b00,
        MODE_UP   = 2'b01,
        MODE_DOWN = 2'b10,
        MODE_LOAD = 2'b11
    } shmode_e;

endpackage

// File: rtl/shreg_next.sv
// Module: shreg_next
// Computes the next register value for each mode, one selector per bit.
// Assumes cur is the present register content. Has no clock.
module shreg_next
    import shreg_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  shmode_e           mode,
    input  logic [WIDTH-1:0]  cur,
    input  logic [WIDTH-1:0]  par_in,
    input  logic              ser_lo,
    input  logic              ser_hi,
    output logic [WIDTH-1:0]  nxt
);

    localparam int TOP = WIDTH - 1;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic from_below;
        logic from_above;
        logic bit_nxt;

        // End bits take the serial inputs; inner bits take their neighbours.
        if (i == 0) begin : g_lo_end
            assign from_below = ser_lo;
        end else begin : g_lo_mid
            assign from_below = cur[i-1];
        end

        if (i == TOP) begin : g_hi_end
            assign from_above = ser_hi;
        end else begin : g_hi_mid
            assign from_above = cur[i+1];
        end

        // Choose this bit's source from the mode.
        always_comb begin
            case (mode)
                MODE_UP:   bit_nxt = from_below;
                MODE_DOWN: bit_nxt = from_above;
                MODE_LOAD: bit_nxt = par_in[i];
                default:   bit_nxt = cur[i];
            endcase
        end

        assign nxt[i] = bit_nxt;
    end

endmodule

// File: rtl/shreg_store.sv
// Module: shreg_store
// The storage flops with a synchronous active-low clear that wins over
// the data path. Assumes rst_n meets setup to clk like any data input.
module shreg_store #(
    parameter int WIDTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WIDTH-1:0]  nxt,
    output logic [WIDTH-1:0]  q
);

    // Capture the next value, or zeros when the clear is asserted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= nxt;
        end
    end

endmodule

// File: rtl/shreg_drive.sv
// Module: shreg_drive
// Decides whether the shared parallel pins are driven. Purely
// combinational: both enables must be low and load must not be selected.
module shreg_drive
    import shreg_pkg::*;
(
    input  logic    en_a_n,
    input  logic    en_b_n,
    input  shmode_e mode,
    output logic    drive
);

    logic enables_ok;
    logic pins_free;

    // Both active-low enables asserted.
    assign enables_ok = ~en_a_n & ~en_b_n;

    // Load mode hands the pins to the external source.
    assign pins_free = (mode != MODE_LOAD);

    assign drive = enables_ok & pins_free;

endmodule

// File: rtl/bidir_shift_reg.sv
// Module: bidir_shift_reg (top)
// A shift/storage register with shared parallel pins. It has hold, shift
// up, shift down and load modes and a synchronous clear. Two always-on end
// taps allow chaining. The shared pins are split into par_in, par_out and
// par_drive; the pad ring merges them.
module bidir_shift_reg
    import shreg_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic              en_a_n,
    input  logic              en_b_n,
    input  logic              ser_lo,
    input  logic              ser_hi,
    input  logic [WIDTH-1:0]  par_in,
    output logic [WIDTH-1:0]  par_out,
    output logic              par_drive,
    output logic              tap_lo,
    output logic              tap_hi
);

    localparam int TOP = WIDTH - 1;

    shmode_e          mode_e;
    logic [WIDTH-1:0] state_q;
    logic [WIDTH-1:0] state_nxt;

    assign mode_e = shmode_e'(mode);

    shreg_next #(.WIDTH(WIDTH)) u_next (
        .mode   (mode_e),
        .cur    (state_q),
        .par_in (par_in),
        .ser_lo (ser_lo),
        .ser_hi (ser_hi),
        .nxt    (state_nxt)
    );

    shreg_store #(.WIDTH(WIDTH)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .nxt   (state_nxt),
        .q     (state_q)
    );

    shreg_drive u_drive (
        .en_a_n (en_a_n),
        .en_b_n (en_b_n),
        .mode   (mode_e),
        .drive  (par_drive)
    );

    // Register contents offered to the pins and to the end taps.
    assign par_out = state_q;
    assign tap_lo  = state_q[0];
    assign tap_hi  = state_q[TOP];

endmodule

// File: rtl/bidir_shift_reg_chk.sv
// Module: bidir_shift_reg_chk
// Property checker attached to every bidir_shift_reg through bind.
// It watches only the top-level ports.
module bidir_shift_reg_chk #(
    parameter int WIDTH = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode,
    input logic              en_a_n,
    input logic              en_b_n,
    input logic              ser_lo,
    input logic              ser_hi,
    input logic [WIDTH-1:0]  par_in,
    input logic [WIDTH-1:0]  par_out,
    input logic              par_drive,
    input logic              tap_lo,
    input logic              tap_hi
);

    logic armed_q;
    logic clr_prev_q;

    // Remember whether the last edge saw the clear asserted.
    always_ff @(posedge clk) begin
        armed_q    <= 1'b1;
        clr_prev_q <= ~rst_n;
    end

    // R1: after an edge with the clear low, the contents are zero.
    always @(negedge clk) begin
        if (armed_q && clr_prev_q) begin
            assert_clear_zeroes_R1: assert (par_out == '0);
        end
    end

    assert_load_takes_pins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b11) |=> (par_out == $past(par_in)));

    assert_shift_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01) |=> (par_out == {$past(par_out[WIDTH-2:0]), $past(ser_lo)}));

    assert_shift_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10) |=> (par_out == {$past(ser_hi), $past(par_out[WIDTH-1:1])}));

    assert_hold_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00) |=> $stable(par_out));

    assert_enable_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en_a_n || en_b_n) |-> !par_drive);

    assert_load_frees_pins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b11) |-> !par_drive);

    assert_taps_track_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tap_lo == par_out[0]) && (tap_hi == par_out[WIDTH-1]));

endmodule

bind bidir_shift_reg bidir_shift_reg_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .en_a_n    (en_a_n),
    .en_b_n    (en_b_n),
    .ser_lo    (ser_lo),
    .ser_hi    (ser_hi),
    .par_in    (par_in),
    .par_out   (par_out),
    .par_drive (par_drive),
    .tap_lo    (tap_lo),
    .tap_hi    (tap_hi)
);

// File: tb/tb_bidir_shift_reg.sv
// Bench: two chained instances (dut is the lower half) checked against a
// 16-bit reference model, with directed corners and seeded random cycles.
module tb_bidir_shift_reg;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [1:0]   mode;
    logic         en_a_n, en_b_n;
    logic         ser_lo, ser_hi;
    logic [W-1:0] pin_lo, pin_hi;
    logic [W-1:0] out_lo, out_hi;
    logic         drv_lo, drv_hi;
    logic         tl_lo, th_lo, tl_hi, th_hi;

    int           n_checks = 0;
    int           n_fail   = 0;
    logic [15:0]  model;

    always #2 clk = ~clk;

    // Lower half: serial inputs ser_lo (bench) and upper tap_lo (chain).
    bidir_shift_reg #(.WIDTH(W)) dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .en_a_n(en_a_n), .en_b_n(en_b_n),
        .ser_lo(ser_lo), .ser_hi(tl_hi), .par_in(pin_lo),
        .par_out(out_lo), .par_drive(drv_lo), .tap_lo(tl_lo), .tap_hi(th_lo)
    );

    // Upper half: serial inputs from the lower tap_hi and ser_hi (bench).
    bidir_shift_reg #(.WIDTH(W)) u_upper (
        .clk(clk), .rst_n(rst_n), .mode(mode), .en_a_n(en_a_n), .en_b_n(en_b_n),
        .ser_lo(th_lo), .ser_hi(ser_hi), .par_in(pin_hi),
        .par_out(out_hi), .par_drive(drv_hi), .tap_lo(tl_hi), .tap_hi(th_hi)
    );

    function automatic logic [15:0] model_next(logic [15:0] m, logic r, logic [1:0] md,
                                               logic sl, logic sh, logic [15:0] p);
        if (!r) return 16'h0000;
        case (md)
            2'b01:   return {m[14:0], sl};
            2'b10:   return {sh, m[15:1]};
            2'b11:   return p;
            default: return m;
        endcase
    endfunction

    function automatic logic drive_exp(logic a, logic b, logic [1:0] md);
        return (!a && !b && md != 2'b11);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive inputs at the falling edge, check the enable, clock once, then
    // compare the state and taps against the model after the rising edge.
    task automatic step(string req, logic r, logic [1:0] md, logic a, logic b,
                        logic sl, logic sh, logic [15:0] p);
        @(negedge clk);
        rst_n = r; mode = md; en_a_n = a; en_b_n = b;
        ser_lo = sl; ser_hi = sh; pin_lo = p[7:0]; pin_hi = p[15:8];
        #1;
        chk("R6/R7 drive", {30'd0, drv_lo, drv_hi}, {30'd0, {2{drive_exp(a, b, md)}}});
        @(posedge clk);
        model = model_next(model, r, md, sl, sh, p);
        #1;
        chk({req, " state"}, {16'd0, out_hi, out_lo}, {16'd0, model});
        chk("R9 taps", {28'd0, tl_lo, th_lo, tl_hi, th_hi},
            {28'd0, model[0], model[7], model[8], model[15]});
    endtask

    // Watchdog: a hung run is a failure and still prints the summary.
    initial begin
        #(200000 * 4);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; mode = 2'b00; en_a_n = 1'b1; en_b_n = 1'b1;
        ser_lo = 1'b0; ser_hi = 1'b0; pin_lo = '0; pin_hi = '0;
        model = 16'h0;

        // R1: clear at reset; then clear competing with load and with shift.
        step("R1 reset", 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000);
        step("R2 load", 1'b1, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 16'h5AA5);
        step("R1 clear beats load", 1'b0, 2'b11, 1'b0, 1'b0, 1'b1, 1'b1, 16'hFFFF);
        step("R2 load", 1'b1, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 16'hC3F0);
        step("R1 clear beats shift", 1'b0, 2'b01, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0000);

        // R3 and R10: a single 1 walks up across the seam between halves.
        step("R3 shift up in", 1'b1, 2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0);
        for (int i = 0; i < 15; i++)
            step("R3 R10 shift up chain", 1'b1, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0);

        // R4 and R10: a 1 walks down from the top end across the seam.
        step("R4 shift down in", 1'b1, 2'b10, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0);
        for (int i = 0; i < 15; i++)
            step("R4 R10 shift down chain", 1'b1, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0);

        // R5: hold ignores the serial and parallel inputs.
        step("R2 load", 1'b1, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 16'h9E37);
        step("R5 hold", 1'b1, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 16'hFFFF);
        step("R5 hold", 1'b1, 2'b00, 1'b1, 1'b0, 1'b0, 1'b1, 16'h0000);

        // R6, R7: all enable/mode combinations of the drive condition.
        for (int e = 0; e < 4; e++)
            for (int m = 0; m < 4; m++)
                step("R6 R7 enable sweep", 1'b1, m[1:0], e[0], e[1], 1'b1, 1'b0, 16'h1234);

        // R8: operations continue with the pins released.
        step("R8 load undriven", 1'b1, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 16'h00FF);
        step("R8 shift up undriven", 1'b1, 2'b01, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0);
        step("R8 shift down undriven", 1'b1, 2'b10, 1'b0, 1'b1, 1'b0, 1'b1, 16'h0);
        step("R8 clear undriven", 1'b0, 2'b10, 1'b1, 1'b1, 1'b1, 1'b1, 16'h0);

        // Random mix; reset asserted about one cycle in sixteen.
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r = $urandom;
            step("R1-mix random", (r[3:0] != 4'd0), r[5:4], r[6], r[7], r[8], r[9], r[31:16]);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule